// File: doc/BRIEF.md
# GF(2) Least-Reliable-Bit Error Pattern Solver

This block finds the most likely error pattern on a small set of low-confidence bit positions of a decoded packet, given the packet's check syndrome. The caller supplies an `M`-bit syndrome, the `L` parity-matrix columns that belong to the `L` least trustworthy positions, and a confidence magnitude for each of those positions. The block solves the linear system `H e = s` over GF(2) for the `L` unknowns. All other positions are assumed to be correct.

Solving runs as a Gauss-Jordan reduction held in an `M`-row by `L`-column register array, plus a syndrome column, with one pivot step per clock. Rows with a single set bit are taken as pivots first. A zero row with a set syndrome bit ends the solve at once. The columns left without a pivot are free variables. Every assignment of them is tried, one per clock. Each assignment fixes the pivot variables and gives a candidate error vector. The winner is the candidate whose flipped positions have the smallest total confidence, which is the same as maximising the sum of (1 - 2e_j) times the confidence. The caller XORs the winner onto its hard decisions and maps it back to packet order. Sorting and that mapping are done outside this block.

A one-cycle `done_o` pulse carries the result: the error vector, a found flag and the winning cost. The result stays on the outputs until the next solve finishes.

Top module: `gf2s_solver`

## Requirements
- R1: When the system has at least one solution and at most `FMAX` free variables, the block reports `found_o`=1 with an `err_o` that satisfies `H e = s`. Column j of `H` is `cols_i[j*M +: M]`, bit i of a column is row i, and bit j of `err_o` is unknown j.
- R2: When `found_o`=1, `cost_o` equals the smallest sum of `gam_i[j*GW +: GW]` over the set bits j, taken over all solutions of `H e = s`. This sum, computed for `err_o`, equals `cost_o`.
- R3: When `H e = s` has no solution, the block reports `found_o`=0, `err_o`=0 and `cost_o`=0.
- R4: When the system is consistent but has more than `FMAX` free variables (L minus the rank of `H`), the block reports `found_o`=0, `err_o`=0 and `cost_o`=0.
- R5: A zero syndrome gives `found_o`=1, `err_o`=0 and `cost_o`=0.
- R6: `done_o` is 0 after reset and is high for exactly one cycle per solve.
- R7: `start_i` and all problem inputs are sampled only when the block is idle. A start pulse or a change of input while a solve is running has no effect on that solve's result.
- R8: `done_o` rises no more than `M + 2^FMAX + 4` clock cycles after the cycle in which a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a solve (taken only when idle) |
| syn_i | input | M | Syndrome vector |
| cols_i | input | L*M | Parity columns of the unreliable positions, column j at bits j*M upward |
| gam_i | input | L*GW | Confidence magnitude per unknown, entry j at bits j*GW upward |
| done_o | output | 1 | One-cycle result strobe |
| found_o | output | 1 | A solution within the free-variable limit was found |
| err_o | output | L | Chosen error vector, one bit per unknown |
| cost_o | output | GW+clog2(L+1) | Total confidence of the flipped positions |

## Verification
The hardest case to reach from the ports is a system that is consistent but rank-deficient, with a free-variable count just inside or just beyond `FMAX`. Random columns over `M` > `L` rows are almost always of full rank. The bench therefore builds such systems on purpose: it zeroes chosen columns and sets the syndrome to `H` times a hidden error vector, so the system has a solution and a known excess of free variables. Separate stimulus classes use sparse, nearly one-hot columns to reach the single-bit-row path, and random syndromes to reach the no-solution path. Every result is compared with an exhaustive search over all 2^L vectors.

// File: rtl/gf2s_pkg.sv
package gf2s_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ELIM = 2'd1,
    ST_ENUM = 2'd2,
    ST_FIN  = 2'd3
  } gf2s_st_e;
endpackage

// File: rtl/gf2s_pivot_pick.sv
// Chooses the next pivot: an unused row of weight one first, else the
// first unused non-zero row; the pivot column is its lowest set bit.
module gf2s_pivot_pick #(
  parameter int M  = 12,
  parameter int L  = 8,
  parameter int RW = 4,
  parameter int CW = 3
) (
  input  logic [M-1:0][L-1:0] rows_i,
  input  logic [M-1:0]        used_i,
  output logic                have_o,
  output logic [RW-1:0]       prow_o,
  output logic [CW-1:0]       pcol_o
);
  logic          single_f, any_f;
  logic [RW-1:0] single_r, any_r;
  logic          col_f;

  always_comb begin
    single_f = 1'b0;
    any_f    = 1'b0;
    single_r = '0;
    any_r    = '0;
    for (int i = 0; i < M; i++) begin
      if (!used_i[i] && ($countones(rows_i[i]) == 1) && !single_f) begin
        single_f = 1'b1;
        single_r = RW'(i);
      end
      if (!used_i[i] && (rows_i[i] != '0) && !any_f) begin
        any_f = 1'b1;
        any_r = RW'(i);
      end
    end
    have_o = single_f | any_f;
    prow_o = single_f ? single_r : any_r;
    pcol_o = '0;
    col_f  = 1'b0;
    for (int j = 0; j < L; j++) begin
      if (rows_i[prow_o][j] && !col_f) begin
        col_f  = 1'b1;
        pcol_o = CW'(j);
      end
    end
  end
endmodule

// File: rtl/gf2s_cand.sv
// Builds one candidate from a free-variable assignment on the reduced system.
module gf2s_cand #(
  parameter int M    = 12,
  parameter int L    = 8,
  parameter int RW   = 4,
  parameter int GW   = 6,
  parameter int FMAX = 4,
  parameter int KW   = 10
) (
  input  logic [M-1:0][L-1:0]  rows_i,
  input  logic [M-1:0]         syn_i,
  input  logic [L-1:0]         piv_i,
  input  logic [L-1:0][RW-1:0] prow_i,
  input  logic [L-1:0][GW-1:0] gam_i,
  input  logic [FMAX:0]        cnt_i,
  output logic [L-1:0]         e_o,
  output logic [KW-1:0]        cost_o
);
  logic [L-1:0] efree;
  int           k;

  always_comb begin
    efree = '0;
    k     = 0;
    for (int j = 0; j < L; j++) begin
      if (!piv_i[j]) begin
        if (k < FMAX) efree[j] = cnt_i[k];
        k = k + 1;
      end
    end
    cost_o = '0;
    for (int j = 0; j < L; j++) begin
      if (piv_i[j]) e_o[j] = syn_i[prow_i[j]] ^ (^(rows_i[prow_i[j]] & efree));
      else          e_o[j] = efree[j];
      if (e_o[j]) cost_o = cost_o + KW'(gam_i[j]);
    end
  end
endmodule

// File: rtl/gf2s_solver.sv
module gf2s_solver #(
  parameter int M    = 12,
  parameter int L    = 8,
  parameter int GW   = 6,
  parameter int FMAX = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [M-1:0]                  syn_i,
  input  logic [L*M-1:0]                cols_i,
  input  logic [L*GW-1:0]               gam_i,
  output logic                          done_o,
  output logic                          found_o,
  output logic [L-1:0]                  err_o,
  output logic [GW+$clog2(L+1)-1:0]     cost_o
);
  import gf2s_pkg::*;

  localparam int RW = (M > 1) ? $clog2(M) : 1;
  localparam int CW = (L > 1) ? $clog2(L) : 1;
  localparam int NW = $clog2(L+1);
  localparam int FW = FMAX + 1;
  localparam int KW = GW + $clog2(L+1);

  gf2s_st_e                st_q, st_d;
  logic [M-1:0][L-1:0]     rows_q, rows_d;
  logic [M-1:0]            syn_q, syn_d;
  logic [M-1:0]            used_q, used_d;
  logic [L-1:0]            piv_q, piv_d;
  logic [L-1:0][RW-1:0]    prow_q, prow_d;
  logic [L-1:0][GW-1:0]    gam_q, gam_d;
  logic [FW-1:0]           cnt_q, cnt_d;
  logic [L-1:0]            be_q, be_d;
  logic [KW-1:0]           bc_q, bc_d;
  logic                    bok_q, bok_d;
  logic                    done_q, done_d, found_q, found_d;
  logic [L-1:0]            err_q, err_d;
  logic [KW-1:0]           cost_q, cost_d;

  logic                    have_piv;
  logic [RW-1:0]           pv_row;
  logic [CW-1:0]           pv_col;
  logic [L-1:0]            cand_e;
  logic [KW-1:0]           cand_cost;
  logic                    bad;
  logic [NW-1:0]           nfree;
  logic [FW-1:0]           last_cnt;

  gf2s_pivot_pick #(.M(M), .L(L), .RW(RW), .CW(CW)) u_pick (
    .rows_i (rows_q), .used_i (used_q),
    .have_o (have_piv), .prow_o (pv_row), .pcol_o (pv_col)
  );

  gf2s_cand #(.M(M), .L(L), .RW(RW), .GW(GW), .FMAX(FMAX), .KW(KW)) u_cand (
    .rows_i (rows_q), .syn_i (syn_q), .piv_i (piv_q), .prow_i (prow_q),
    .gam_i (gam_q), .cnt_i (cnt_q), .e_o (cand_e), .cost_o (cand_cost)
  );

  // zero coefficient row with a set syndrome bit: inconsistent system
  always_comb begin
    bad = 1'b0;
    for (int i = 0; i < M; i++) bad = bad | ((rows_q[i] == '0) & syn_q[i]);
  end

  always_comb begin
    nfree = '0;
    for (int j = 0; j < L; j++) if (!piv_q[j]) nfree = nfree + NW'(1);
  end

  assign last_cnt = (FW'(1) << nfree) - FW'(1);

  always_comb begin
    st_d = st_q;   rows_d = rows_q; syn_d = syn_q;   used_d = used_q;
    piv_d = piv_q; prow_d = prow_q; gam_d = gam_q;   cnt_d = cnt_q;
    be_d = be_q;   bc_d = bc_q;     bok_d = bok_q;
    done_d = 1'b0; found_d = found_q; err_d = err_q; cost_d = cost_q;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          for (int i = 0; i < M; i++)
            for (int j = 0; j < L; j++) rows_d[i][j] = cols_i[j*M+i];
          syn_d  = syn_i;
          gam_d  = gam_i;
          used_d = '0;
          piv_d  = '0;
          prow_d = '0;
          be_d   = '0;
          bc_d   = '0;
          bok_d  = 1'b0;
          st_d   = ST_ELIM;
        end
      end
      ST_ELIM: begin
        if (bad) begin
          st_d = ST_FIN;
        end else if (have_piv) begin
          for (int i = 0; i < M; i++) begin
            if ((RW'(i) != pv_row) && rows_q[i][pv_col]) begin
              rows_d[i] = rows_q[i] ^ rows_q[pv_row];
              syn_d[i]  = syn_q[i] ^ syn_q[pv_row];
            end
          end
          used_d[pv_row] = 1'b1;
          piv_d[pv_col]  = 1'b1;
          prow_d[pv_col] = pv_row;
        end else if (int'(nfree) > FMAX) begin
          st_d = ST_FIN;
        end else begin
          cnt_d = '0;
          st_d  = ST_ENUM;
        end
      end
      ST_ENUM: begin
        if (!bok_q || (cand_cost < bc_q)) begin
          be_d  = cand_e;
          bc_d  = cand_cost;
          bok_d = 1'b1;
        end
        if (cnt_q == last_cnt) st_d = ST_FIN;
        else                   cnt_d = cnt_q + FW'(1);
      end
      ST_FIN: begin
        done_d  = 1'b1;
        found_d = bok_q;
        err_d   = be_q;
        cost_d  = bc_q;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;   rows_q <= '0; syn_q <= '0;   used_q <= '0;
      piv_q <= '0;       prow_q <= '0; gam_q <= '0;   cnt_q <= '0;
      be_q <= '0;        bc_q <= '0;   bok_q <= 1'b0;
      done_q <= 1'b0;    found_q <= 1'b0; err_q <= '0; cost_q <= '0;
    end else begin
      st_q <= st_d;      rows_q <= rows_d; syn_q <= syn_d; used_q <= used_d;
      piv_q <= piv_d;    prow_q <= prow_d; gam_q <= gam_d; cnt_q <= cnt_d;
      be_q <= be_d;      bc_q <= bc_d;     bok_q <= bok_d;
      done_q <= done_d;  found_q <= found_d; err_q <= err_d; cost_q <= cost_d;
    end
  end

  assign done_o  = done_q;
  assign found_o = found_q;
  assign err_o   = err_q;
  assign cost_o  = cost_q;
endmodule

// File: rtl/gf2s_solver_chk.sv
module gf2s_solver_chk #(
  parameter int L    = 8,
  parameter int GW   = 6,
  parameter int FMAX = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        done_o,
  input logic                        found_o,
  input logic [L-1:0]                err_o,
  input logic [GW+$clog2(L+1)-1:0]   cost_o,
  input logic [1:0]                  st,
  input logic [L-1:0][GW-1:0]        gam_q,
  input logic [$clog2(L+1)-1:0]      nfree,
  input logic [FMAX:0]               cnt
);
  import gf2s_pkg::*;

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_fail_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !found_o) |-> (err_o == '0 && cost_o == '0));

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'(ST_IDLE)) |=> $stable(gam_q));

  p_free_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'(ST_ENUM)) |-> (int'(nfree) <= FMAX));

  p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'(ST_ENUM)) |-> (int'(cnt) < (1 << nfree)));
endmodule

bind gf2s_solver gf2s_solver_chk #(.L(L), .GW(GW), .FMAX(FMAX)) u_chk (
  .clk (clk), .rst_n (rst_n), .done_o (done_o), .found_o (found_o),
  .err_o (err_o), .cost_o (cost_o), .st (st_q), .gam_q (gam_q),
  .nfree (nfree), .cnt (cnt_q)
);

// File: tb/gf2s_solver_tb.sv
module gf2s_solver_tb;
  localparam int M    = 12;
  localparam int L    = 8;
  localparam int GW   = 6;
  localparam int FMAX = 4;
  localparam int KW   = GW + $clog2(L+1);
  localparam int CLK_PERIOD = 10;
  localparam int LAT  = M + (1 << FMAX) + 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [M-1:0]      syn_i = '0;
  logic [L*M-1:0]    cols_i = '0;
  logic [L*GW-1:0]   gam_i = '0;
  logic              done_o, found_o;
  logic [L-1:0]      err_o;
  logic [KW-1:0]     cost_o;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gf2s_solver #(.M(M), .L(L), .GW(GW), .FMAX(FMAX)) u_dut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .syn_i (syn_i),
    .cols_i (cols_i), .gam_i (gam_i), .done_o (done_o), .found_o (found_o),
    .err_o (err_o), .cost_o (cost_o)
  );

  function automatic logic [M-1:0] hmul(logic [L*M-1:0] c, logic [L-1:0] e);
    logic [M-1:0] r = '0;
    for (int j = 0; j < L; j++) if (e[j]) r = r ^ c[j*M +: M];
    return r;
  endfunction

  function automatic int wcost(logic [L*GW-1:0] g, logic [L-1:0] e);
    int s = 0;
    for (int j = 0; j < L; j++) if (e[j]) s += int'(g[j*GW +: GW]);
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input logic [M-1:0] s, input logic [L*M-1:0] c,
                          input logic [L*GW-1:0] g, input bit disturb);
    int  best = -1;
    int  hcnt = 0;
    int  f;
    int  waited;
    bit  exp_found;
    string tag;
    // exhaustive reference
    for (int e = 0; e < (1 << L); e++) begin
      if (hmul(c, L'(e)) == '0) hcnt++;
      if (hmul(c, L'(e)) == s) begin
        if (best < 0 || wcost(g, L'(e)) < best) best = wcost(g, L'(e));
      end
    end
    f = $clog2(hcnt);
    exp_found = (best >= 0) && (f <= FMAX);
    tag = (best < 0) ? "R3" : (f > FMAX) ? "R4" : (s == '0) ? "R5" : "R1";

    @(negedge clk);
    syn_i = s; cols_i = c; gam_i = g; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    waited = 1;
    if (disturb) begin
      // R7: second start and new operands while busy
      @(negedge clk);
      waited++;
      syn_i = ~s; cols_i = ~c; gam_i = ~g; start_i = 1'b1;
      @(negedge clk);
      waited++;
      start_i = 1'b0;
    end
    while (!done_o && waited <= LAT + 2) begin
      @(negedge clk);
      waited++;
    end
    check(done_o == 1'b1 && waited <= LAT, "R8", "done latency", waited, LAT);
    if (done_o) begin
      check(found_o == exp_found, disturb ? "R7" : tag, "found flag",
            int'(found_o), int'(exp_found));
      if (exp_found) begin
        check(hmul(c, err_o) == s, "R1", "syndrome of err", int'(hmul(c, err_o)), int'(s));
        check(int'(cost_o) == best, "R2", "minimum cost", int'(cost_o), best);
        check(wcost(g, err_o) == int'(cost_o), "R2", "cost of err", wcost(g, err_o), int'(cost_o));
        if (s == '0) check(err_o == '0 && cost_o == '0, "R5", "zero syndrome", int'(err_o), 0);
      end else begin
        check(err_o == '0 && cost_o == '0, (best < 0) ? "R3" : "R4",
              "cleared outputs", int'(err_o), 0);
      end
      @(negedge clk);
      check(done_o == 1'b0, "R6", "done single cycle", int'(done_o), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [M-1:0]    s;
    logic [L*M-1:0]  c;
    logic [L*GW-1:0] g;
    logic [L-1:0]    e0;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    check(done_o == 1'b0 && found_o == 1'b0, "R6", "reset state",
          int'(done_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int t = 0; t < 360; t++) begin
      for (int j = 0; j < L; j++) begin
        c[j*M +: M]   = M'($urandom);
        g[j*GW +: GW] = GW'($urandom);
      end
      e0 = L'($urandom) & L'($urandom);
      case (t % 6)
        0: s = '0;
        1: s = hmul(c, e0);
        2: s = M'($urandom);
        3: begin
          for (int z = 0; z < 1 + (t / 6) % 3; z++) c[((t + 3*z) % L)*M +: M] = '0;
          if (t % 12 == 3) c[((t + 1) % L)*M +: M] = c[((t + 2) % L)*M +: M];
          s = hmul(c, e0);
        end
        4: begin
          for (int z = 0; z < 5 + (t / 6) % 2; z++) c[((t + z) % L)*M +: M] = '0;
          s = hmul(c, e0);
        end
        default: begin
          for (int j = 0; j < L; j++)
            c[j*M +: M] = (M'(1) << ($urandom % M)) | ((t % 4 == 1) ? (M'(1) << ($urandom % M)) : '0);
          s = (t % 12 == 5) ? M'($urandom) : hmul(c, e0);
        end
      endcase
      run_case(s, c, g, (t % 10 == 7));
    end

    // corner: all columns zero, zero syndrome: too many free variables
    run_case('0, '0, '1, 1'b0);
    // corner: all columns zero, non-zero syndrome: no solution
    run_case(M'(1), '0, '1, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule